// File: doc/BRIEF.md
# Stereo Digital Volume with Master Offset

This block scales a stereo stream of signed 18-bit PCM samples by a per-channel gain in half-decibel steps. Each channel's attenuation code is added to one shared master code. The combined code is turned into a linear gain: a right shift of one bit for every twelve codes, and a twelve-entry fraction for the steps in between. The scaled result is saturated to the sample width. A small write port loads the three codes. A manual mute silences both channels. An invalid-input flag can also mute both channels when its enable is set.

A sample pair enters on a one-cycle `in_valid` strobe. The codes that will scale the pair are taken from the written values at that same strobe, so a write never takes effect partway through a sample pair. The scaled pair appears two clock edges after the strobe, together with a one-cycle `out_valid` pulse. The outputs then hold their values until the next result.

Top module: `stereo_vol`

## Requirements
- R1: After reset, `out_left`, `out_right`, `out_valid` and `muted` are 0. The left and right codes reset to 0x48 and the master code resets to 0x00.
- R2: On a cycle with `wr_en` high, `wr_addr` selects which code takes `wr_data`: 0 selects left, 1 selects right, 2 selects master. Address 3 changes no code.
- R3: The combined code for a channel is a = channel code + master code, a 9-bit value. The gain is f(a mod 12) · 2^(6 − floor(a/12)) / 32768, where f(r) = round(32768 · 2^(−r/12)). The output is floor(x · f · 2^6 / 2^(15+floor(a/12))), which is an arithmetic right shift of x·f by 9 + floor(a/12) bits.
- R4: With a channel code of 0x48 and a master code of 0, the output equals the input.
- R5: A scaled value above 131071 saturates to 131071. A scaled value below −131072 saturates to −131072.
- R6: When a > 282 (beyond −105 dB), that channel's output is 0. At a = 282 the normal scaling of R3 still applies.
- R7: When `mute` is high with a sample, both outputs are 0 and `muted` is 1 for that result.
- R8: When `in_invalid` and `inv_mute_en` are both high with a sample, both outputs are 0 and `muted` is 1. When `in_invalid` is high but `inv_mute_en` is low, the sample is scaled normally.
- R9: The codes used for a sample are the ones written before the cycle of its `in_valid` strobe. A write in the same cycle as the strobe applies from the next sample on.
- R10: A result appears with `out_valid` high two rising edges after the edge that captured `in_valid`. Between results, `out_left`, `out_right` and `muted` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Code write strobe |
| wr_addr | input | 2 | Code select: 0 left, 1 right, 2 master |
| wr_data | input | 8 | Code value |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 18 | Left input sample, signed |
| in_right | input | 18 | Right input sample, signed |
| in_invalid | input | 1 | Input flagged invalid, sampled with in_valid |
| mute | input | 1 | Manual mute, sampled with in_valid |
| inv_mute_en | input | 1 | Enables mute on invalid input, sampled with in_valid |
| out_valid | output | 1 | Result strobe |
| out_left | output | 18 | Left output sample, signed |
| out_right | output | 18 | Right output sample, signed |
| muted | output | 1 | Mute state of the latest result |

## Verification
Several properties are checked on every cycle:
- the fixed two-edge latency;
- held outputs between results;
- the active codes changing only on a sample strobe;
- zero outputs whenever a muted result is presented;
- the mute status following an enabled invalid flag.

The arithmetic itself can only be shown by the bench scenarios. That covers the gain curve across all combined codes, saturation at both rails, and the −105 dB cut-off boundary. The bench scenarios also show that a write arriving together with a strobe is deferred to the next sample.

// File: rtl/stereo_vol.sv
module stereo_vol #(
  parameter int DW        = 18,
  parameter int CW        = 8,
  parameter int UNITY     = 8'h48,
  parameter int CUT_CODE  = 282
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CW-1:0]        wr_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic                 in_invalid,
  input  logic                 mute,
  input  logic                 inv_mute_en,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right,
  output logic                 muted
);
  localparam int PW = DW + 17;
  localparam logic [CW:0] CUT = (CW+1)'(CUT_CODE);
  localparam logic signed [PW-1:0] SMAX = PW'((64'sd1 <<< (DW-1)) - 64'sd1);
  localparam logic signed [PW-1:0] SMIN = -SMAX - PW'(1);

  logic [CW-1:0] sh_l, sh_r, sh_m, lv_l, lv_r, lv_m;
  logic signed [DW-1:0] s_l, s_r, y_l, y_r;
  logic s_mute, sv;

  function automatic logic [15:0] frac_lut(input logic [3:0] r);
    case (r)
      4'd0:  return 16'd32768;
      4'd1:  return 16'd30929;
      4'd2:  return 16'd29193;
      4'd3:  return 16'd27554;
      4'd4:  return 16'd26008;
      4'd5:  return 16'd24548;
      4'd6:  return 16'd23170;
      4'd7:  return 16'd21870;
      4'd8:  return 16'd20643;
      4'd9:  return 16'd19484;
      4'd10: return 16'd18390;
      default: return 16'd17358;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                  input logic [CW-1:0] c,
                                                  input logic [CW-1:0] m);
    logic [CW:0] a, q;
    logic [3:0] r;
    logic signed [PW-1:0] p, v;
    a = {1'b0, c} + {1'b0, m};
    if (a > CUT) return '0;
    q = a / (CW+1)'(12);
    r = 4'(a % (CW+1)'(12));
    p = x * $signed({1'b0, frac_lut(r)});
    v = p >>> (q + (CW+1)'(9));
    if (v > SMAX) return SMAX[DW-1:0];
    if (v < SMIN) return SMIN[DW-1:0];
    return v[DW-1:0];
  endfunction

  assign y_l = scale(s_l, lv_l, lv_m);
  assign y_r = scale(s_r, lv_r, lv_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_l <= CW'(UNITY); sh_r <= CW'(UNITY); sh_m <= '0;
      lv_l <= CW'(UNITY); lv_r <= CW'(UNITY); lv_m <= '0;
      s_l <= '0; s_r <= '0; s_mute <= 1'b0; sv <= 1'b0;
      out_valid <= 1'b0; out_left <= '0; out_right <= '0; muted <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: sh_l <= wr_data;
          2'd1: sh_r <= wr_data;
          2'd2: sh_m <= wr_data;
          default: ;
        endcase
      end
      sv <= in_valid;
      if (in_valid) begin
        lv_l <= sh_l; lv_r <= sh_r; lv_m <= sh_m;
        s_l <= in_left; s_r <= in_right;
        s_mute <= mute | (in_invalid & inv_mute_en);
      end
      out_valid <= sv;
      if (sv) begin
        muted     <= s_mute;
        out_left  <= s_mute ? '0 : y_l;
        out_right <= s_mute ? '0 : y_r;
      end
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sv |=> $stable(out_left) && $stable(out_right) && $stable(muted));
  p_codes_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(lv_l) && $stable(lv_r) && $stable(lv_m));
  p_mute_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && muted |-> out_left == '0 && out_right == '0);
  p_invalid_mute_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_invalid && inv_mute_en |=> ##1 muted);
endmodule

// File: tb/stereo_vol_test.sv
`timescale 1ns/1ps
module stereo_vol_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [1:0] wr_addr = '0; logic [7:0] wr_data = '0;
  logic in_valid = 1'b0, in_invalid = 1'b0, mute = 1'b0, inv_mute_en = 1'b0;
  logic signed [17:0] in_left = '0, in_right = '0;
  logic out_valid, muted;
  logic signed [17:0] out_left, out_right;
  int checks = 0, errors = 0;
  int bl = 8'h48, br = 8'h48, bm = 0;

  always #2.5 clk = ~clk;

  stereo_vol uut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .in_valid, .in_left,
                  .in_right, .in_invalid, .mute, .inv_mute_en, .out_valid,
                  .out_left, .out_right, .muted);

  function automatic int expect_ch(int x, int c, int m);
    int a, q, r, f; longint p, v;
    a = c + m;
    if (a > 282) return 0;
    q = a / 12; r = a % 12;
    f = $rtoi(32768.0 * (2.0 ** (-r / 12.0)) + 0.5);
    p = longint'(x) * f;
    v = p >>> (9 + q);
    if (v > 131071) return 131071;
    if (v < -131072) return -131072;
    return int'(v);
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 8'(data);
    @(negedge clk); wr_en = 1'b0;
    if (addr == 0) bl = data; else if (addr == 1) br = data; else if (addr == 2) bm = data;
  endtask

  task automatic send(string req, int l, int r, bit inv, bit mu, bit en);
    bit m; int el, er;
    @(negedge clk);
    in_valid = 1'b1; in_left = 18'(l); in_right = 18'(r);
    in_invalid = inv; mute = mu; inv_mute_en = en;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    m = mu | (inv & en);
    el = m ? 0 : expect_ch(l, bl, bm);
    er = m ? 0 : expect_ch(r, br, bm);
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " left"}, int'(out_left), el);
    chk({req, " right"}, int'(out_right), er);
    chk({req, " muted"}, int'(muted), int'(m));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_left", int'(out_left), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 muted", int'(muted), 0);
    rst_n = 1'b1;
    // R1 reset codes, R4 unity
    send("R1 R4 unity", 12345, -54321, 0, 0, 0);
    send("R4 unity extremes", 131071, -131072, 0, 0, 0);
    // R2 writes, R3 gain
    wr(0, 8'h50); wr(1, 8'h30); wr(2, 5);
    send("R2 R3 scaled", 70000, -70000, 0, 0, 0);
    wr(3, 8'hAA);
    send("R2 addr3 ignored", 70000, -70000, 0, 0, 0);
    // R5 saturation
    wr(0, 0); wr(1, 0); wr(2, 0);
    send("R5 sat", 100000, -100000, 0, 0, 0);
    send("R5 small", 2000, -2000, 0, 0, 0);
    // R6 cut-off boundary: 255+27=282, 255+28=283
    wr(0, 255); wr(1, 255); wr(2, 27);
    send("R6 at 282", -131072, 131071, 0, 0, 0);
    chk("R6 at 282 left -1", int'(out_left), -1);
    wr(2, 28);
    send("R6 at 283", -131072, 131071, 0, 0, 0);
    chk("R6 at 283 left 0", int'(out_left), 0);
    // R7 / R8
    wr(0, 8'h48); wr(1, 8'h40); wr(2, 0);
    send("R7 mute", 5000, 6000, 0, 1, 0);
    send("R8 auto mute", 5000, 6000, 1, 0, 1);
    send("R8 invalid no enable", 5000, 6000, 1, 0, 0);
    // R9 write on the strobe cycle is deferred
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h60;
    in_valid = 1'b1; in_left = 18'sd40000; in_right = 18'sd0; in_invalid = 0; mute = 0;
    @(negedge clk); wr_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk("R9 old code used", int'(out_left), expect_ch(40000, 8'h48, 0));
    bl = 8'h60;
    send("R9 new code next", 40000, 0, 0, 0, 0);
    // R10 hold between results
    @(negedge clk);
    chk("R10 valid pulse", int'(out_valid), 0);
    chk("R10 hold", int'(out_left), expect_ch(40000, 8'h60, 0));
    // random mix
    void'($urandom(32'd2024));
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) == 0) wr(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
      send("R3 random", int'($urandom_range(0, 262143)) - 131072,
           int'($urandom_range(0, 262143)) - 131072,
           $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule